// File: doc/BRIEF.md
# Lockable Bus-Programmed Watchdog Timer

This block supervises system software. It counts down a timeout measured in whole seconds and, when the countdown runs out, raises a reset request for the system reset generator. A seconds prescaler divides the system clock to produce the one-second steps, and its divide ratio is a parameter. Software controls the block through a small 32-bit register bus with an address, a write strobe, write data and combinational read data.

A control word holds an arm bit and a 4-bit timeout field. Once the arm bit is set, it stays set until the next system reset. Every write to the control word restarts the full timeout, whatever data it carries, so that write is also how software services the watchdog. Software may change the timeout field while the timer runs. The new value applies from that write.

A status word holds a cause flag that is set on every expiry. The system reset does not clear it, so after a restart software can tell whether the watchdog caused the last reset. Only the power-on reset, or a write of 1 to the flag's bit, clears it.

Top module: `wdog_lock`

## Requirements
- R1: After power-on reset the control word (byte address 0x14) and the status word (byte address 0x18) both read 0x00000000, and `wdt_rst_req` is low.
- R2: Writing the control word with bit 7 set arms the watchdog, and bit 7 then reads back as 1.
- R3: Once armed, the watchdog stays armed until `rst_n` is asserted, even when a later control write has bit 7 clear.
- R4: Every write to the control word reloads the countdown, whatever value is written, so the next expiry comes a full timeout after that write.
- R5: Bits 11:8 of the control word give the timeout N in seconds. The first expiry after a control write with N in 1..15 comes exactly N*CLK_HZ clock edges after the edge that captured the write.
- R6: A timeout field of 0 behaves as a timeout of 1 second.
- R7: Rewriting the timeout field while the watchdog is armed takes effect at once: the next expiry is timed from that write using the new value.
- R8: Control reads return the timeout in bits 11:8 and the arm bit in bit 7. Every other bit reads as 0.
- R9: An expiry sets status bit 31, and an `rst_n` pulse does not clear it. `rst_n` does clear the arm bit and the timeout field.
- R10: Status bit 31 is cleared by `por_n` or by writing 1 to status bit 31. Writing 0 to that bit leaves it unchanged.
- R11: While the watchdog is not armed, `wdt_rst_req` never asserts.
- R12: `wdt_rst_req` is high for exactly one clock cycle per expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything including the cause flag |
| rst_n | input | 1 | System reset, active low, asynchronous; clears everything except the cause flag |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | Single-cycle reset request on expiry |

## Verification
A corrupted prescaler or seconds counter shows up as an expiry edge that comes early or late. The bench times every expiry to the exact cycle from the capturing write, so an error of one clock is caught on the first timeout. A broken arm lock or cause flag appears on the very next read of the control or status word. The bench reads those words straight after the stimulus that could have disturbed them, including a write with the arm bit clear and a system reset pulse.

// File: rtl/lwdt_pkg.sv
package lwdt_pkg;

    typedef struct packed {
        logic       armed;
        logic [3:0] secs;
    } ctl_t;

    // A zero field counts as one second
    function automatic logic [3:0] eff_secs(input logic [3:0] field);
        return (field == 4'd0) ? 4'd1 : field;
    endfunction

endpackage

// File: rtl/lwdt_prescale.sv
module lwdt_prescale #(
    parameter int CLK_HZ = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && !clr && (st_q.cnt == LAST);
        if (clr) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/lwdt_countdown.sv
module lwdt_countdown (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       load,
    input  logic [3:0] load_secs,
    input  logic [3:0] cur_secs,
    input  logic       tick,
    output logic       fire,
    output logic       req
);
    typedef struct packed {
        logic [3:0] left;
        logic       req;
    } cd_t;

    cd_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        fire     = run && !load && tick && (st_q.left == 4'd1);
        st_d.req = fire;
        if (load) begin
            st_d.left = load_secs;
        end else if (run && tick) begin
            st_d.left = fire ? cur_secs : st_q.left - 4'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{left: 4'd1, req: 1'b0};
        else        st_q <= st_d;
    end

    assign req = st_q.req;
endmodule

// File: rtl/lwdt_regs.sv
module lwdt_regs
    import lwdt_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h14,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [31:0]       wdata,
    input  logic              fire,
    output logic              armed,
    output logic [3:0]        cur_secs,
    output logic              kick,
    output logic [3:0]        kick_secs,
    output logic              cause,
    output logic [31:0]       rdata
);
    ctl_t ctl_d, ctl_q;
    logic flag_d, flag_q;
    logic clr_flag;
    logic unused_bits;

    assign unused_bits = ^{wdata[30:12], wdata[6:0]};

    always_comb begin
        ctl_d     = ctl_q;
        kick      = wr && (addr == CTRL_OFS);
        clr_flag  = wr && (addr == STAT_OFS) && wdata[31];
        kick_secs = eff_secs(wdata[11:8]);
        if (kick) begin
            ctl_d.armed = ctl_q.armed | wdata[7];
            ctl_d.secs  = wdata[11:8];
        end
        // expiry has priority over a software clear in the same cycle
        flag_d = (flag_q && !clr_flag) || fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_OFS) begin
            rdata[11:8] = ctl_q.secs;
            rdata[7]    = ctl_q.armed;
        end else if (addr == STAT_OFS) begin
            rdata[31]   = flag_q;
        end
    end

    assign armed    = ctl_q.armed;
    assign cur_secs = eff_secs(ctl_q.secs);
    assign cause    = flag_q;
endmodule

// File: rtl/wdog_lock.sv
module wdog_lock #(
    parameter int                CLK_HZ   = 50_000_000,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h14,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h18
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_req
);
    logic       sys_n;
    logic       armed_w, kick_w, tick_w, fire_w, cause_w;
    logic [3:0] cur_secs_w, kick_secs_w;

    // power-on reset also resets the system domain
    assign sys_n = rst_n & por_n;

    lwdt_regs #(
        .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
    ) u_regs (
        .clk(clk), .rst_n(sys_n), .por_n(por_n),
        .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .fire(fire_w), .armed(armed_w), .cur_secs(cur_secs_w),
        .kick(kick_w), .kick_secs(kick_secs_w), .cause(cause_w),
        .rdata(bus_rdata)
    );

    lwdt_prescale #(.CLK_HZ(CLK_HZ)) u_pre (
        .clk(clk), .rst_n(sys_n), .run(armed_w), .clr(kick_w), .tick(tick_w)
    );

    lwdt_countdown u_cd (
        .clk(clk), .rst_n(sys_n), .run(armed_w), .load(kick_w),
        .load_secs(kick_secs_w), .cur_secs(cur_secs_w), .tick(tick_w),
        .fire(fire_w), .req(wdt_rst_req)
    );
endmodule

// File: rtl/wdog_lock_chk.sv
module wdog_lock_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h14,
    parameter logic [ADDR_W-1:0] STAT_OFS = 'h18
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              wdt_rst_req,
    input logic              armed,
    input logic              cause
);
    // R12
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        wdt_rst_req |=> !wdt_rst_req);

    // R3
    arm_lock_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        armed |=> armed);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !armed |-> !wdt_rst_req);

    // R9
    cause_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        wdt_rst_req |-> cause);

    // R4
    kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (bus_wr && bus_addr == CTRL_OFS) |=> !wdt_rst_req);

    // R10
    cause_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cause && !(bus_wr && bus_addr == STAT_OFS && bus_wdata[31])) |=> cause);
endmodule

bind wdog_lock wdog_lock_chk #(
    .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .wdt_rst_req(wdt_rst_req),
    .armed(armed_w), .cause(cause_w)
);

// File: tb/wdog_lock_bench.sv
`timescale 1ns/1ps
module wdog_lock_bench;
    localparam int HZ = 4;
    localparam logic [7:0] CTRL = 8'h14;
    localparam logic [7:0] STAT = 8'h18;

    // {timeout field, expected seconds}
    localparam logic [7:0] VEC [6] = '{8'h11, 8'h01, 8'h33, 8'h22, 8'hFF, 8'h77};

    logic        clk = 0;
    logic        por_n = 0, rst_n = 0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    int runs = 0, fails = 0;

    always #10 clk = ~clk;

    wdog_lock #(.CLK_HZ(HZ)) u_wdog_lock (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_req(wdt_rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // counts edges after the capturing write until the request is seen
    task automatic time_req(input int limit, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!wdt_rst_req && k < limit);
    endtask

    task automatic quiet(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst_req) hits++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int k, h;
        repeat (3) @(negedge clk);
        por_n = 1; rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(CTRL, r); check("R1 ctrl", r, 32'h0);
        rd(STAT, r); check("R1 stat", r, 32'h0);
        check("R1 req", {31'b0, wdt_rst_req}, 32'h0);

        // R11 unarmed timer stays silent
        wr(CTRL, 32'h0000_0100);
        quiet(40, h); check("R11 no req", h, 0);
        rd(CTRL, r); check("R11 ctrl", r, 32'h0000_0100);

        // R5 R6 table of timeouts
        foreach (VEC[i]) begin
            wr(CTRL, {20'b0, VEC[i][7:4], 8'h80});
            time_req(200, k);
            check(i == 1 ? "R6 zero field" : "R5 expiry", k, VEC[i][3:0] * HZ);
            @(negedge clk);
            check("R12 single", {31'b0, wdt_rst_req}, 32'h0);
        end

        // R2 R8 read format
        wr(CTRL, 32'hFFFF_FFFF);
        rd(CTRL, r); check("R8 ctrl bits", r, 32'h0000_0F80);
        // R3 lock: arm bit clear in data
        wr(CTRL, 32'h0000_0200);
        rd(CTRL, r); check("R3 lock", r, 32'h0000_0280);
        check("R2 armed", {31'b0, r[7]}, 32'h1);

        // R4 kick postpones expiry
        wr(CTRL, 32'h0000_0280);
        quiet(6, h); check("R4 early", h, 0);
        wr(CTRL, 32'h0000_0200);
        time_req(200, k); check("R4 reload", k, 2 * HZ);

        // R7 change timeout while running
        wr(CTRL, 32'h0000_0380);
        quiet(5, h);
        wr(CTRL, 32'h0000_0100);
        time_req(200, k); check("R7 new tmo", k, 1 * HZ);

        // R9 flag survives system reset
        rd(STAT, r); check("R9 flag set", r, 32'h8000_0000);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        rd(STAT, r); check("R9 after rst", r, 32'h8000_0000);
        rd(CTRL, r); check("R9 ctrl cleared", r, 32'h0);

        // R10 clear rules
        wr(STAT, 32'h7FFF_FFFF);
        rd(STAT, r); check("R10 write0", r, 32'h8000_0000);
        wr(STAT, 32'h8000_0000);
        rd(STAT, r); check("R10 write1", r, 32'h0);
        wr(CTRL, 32'h0000_0180);
        time_req(200, k); check("R10 re-expire", k, HZ);
        @(negedge clk); por_n = 0;
        @(negedge clk); por_n = 1;
        rd(STAT, r); check("R10 por", r, 32'h0);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule